// File: doc/BRIEF.md
# Banked CPU Address Decoder

This block sits between an 8-bit CPU and the memories and peripherals of a small arcade-style board. It splits the 16-bit memory space into chip selects for a fixed program ROM, a 16 KB banked ROM window, work RAM, two palette RAM halves, two tile-code RAMs and a colour RAM. For every ROM access it also produces the physical ROM address, so that the window can reach ROM beyond the CPU's 64 KB reach.

A separate 8-bit I/O space carries read strobes for four DIP-switch banks and three input ports, a write strobe for the sound chip, and a write-only bank register. The bank register shares its port number with one of the input ports: reads of that port go to the input port and writes go to the register. A small latch holds the CPU interrupt from the start of vertical blank until the CPU acknowledges it.

All selects and strobes are combinational from the address and the read/write strobes. Only the bank register and the interrupt latch hold state.

Top module: `cpu_bus_decoder`

## Requirements
- R1: A memory read in 0x0000–0x7FFF asserts `rom_fix_cs_o`, and `rom_addr_o` equals the CPU address.
- R2: A memory read in 0x8000–0xBFFF asserts `rom_bank_cs_o`, and `rom_addr_o` = 0x10000 + 0x4000 × bank + address[13:0].
- R3: An I/O write to port 0xA0 loads bits [2:0] of the write data into the bank register at the clock edge. Upper data bits are ignored. Reset clears the register to 0. No other cycle changes it, and `bank_o` shows its value.
- R4: An I/O read of port 0xA0 asserts input-port strobe 1 and leaves the bank register unchanged.
- R5: A memory read or write asserts `wram_cs_o` in 0xC000–0xC7FF, `pal_lo_cs_o` in 0xC800–0xCBFF and `pal_hi_cs_o` in 0xCC00–0xCFFF.
- R6: A memory read or write asserts `tile_lo_cs_o` in 0xD000–0xD7FF, `tile_hi_cs_o` in 0xD800–0xDFFF and `color_cs_o` in 0xE000–0xE7FF.
- R7: An access in 0xE800–0xFFFF asserts no chip select. A read there asserts `hole_rd_o`, which tells the board to drive 0xFF onto the data bus.
- R8: The I/O decode uses only `io_addr_i[7:0]`. Bits [15:8] have no effect on any strobe or on the bank register.
- R9: I/O reads assert `dsw_rd_o[k]` at port 0x20 × k for k = 0 to 3. They assert `in_rd_o[0]` at 0x80, `in_rd_o[1]` at 0xA0 and `in_rd_o[2]` at 0xE0.
- R10: An I/O write to 0x40 or 0x41 asserts `snd_wr_o`, and `snd_a0_o` carries address bit 0 (0 = register address, 1 = data).
- R11: A rising edge of `vblank_i` sets `irq_o` on the next clock edge. `irq_o` then stays high until a cycle with `irq_ack_i` high, after which it clears. When a new rising edge arrives in the same cycle as an acknowledge, the new edge wins.
- R12: With no read or write strobe, no select or strobe is asserted. At most one memory select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_i | input | 16 | CPU memory address |
| mem_rd_i | input | 1 | Memory read strobe |
| mem_wr_i | input | 1 | Memory write strobe |
| io_addr_i | input | 16 | CPU I/O address (low byte decoded) |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| vblank_i | input | 1 | Vertical blank level |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| rom_fix_cs_o | output | 1 | Fixed ROM select |
| rom_bank_cs_o | output | 1 | Banked ROM window select |
| rom_addr_o | output | 18 | Physical ROM address |
| wram_cs_o | output | 1 | Work RAM select |
| pal_lo_cs_o | output | 1 | Low palette half select |
| pal_hi_cs_o | output | 1 | High palette half select |
| tile_lo_cs_o | output | 1 | Low tile-code RAM select |
| tile_hi_cs_o | output | 1 | High tile-code RAM select |
| color_cs_o | output | 1 | Colour RAM select |
| hole_rd_o | output | 1 | Read of unmapped space (bus reads 0xFF) |
| dsw_rd_o | output | 4 | DIP-switch bank read strobes |
| in_rd_o | output | 3 | Input-port read strobes |
| snd_wr_o | output | 1 | Sound chip write strobe |
| snd_a0_o | output | 1 | Sound chip register/data select |
| bank_o | output | 3 | Current bank register value |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit memory address, a 16-bit I/O address, a 3-bit bank and an 18-bit ROM address. With these values all eight banks are reachable, including the last window at 0x2C000–0x2FFFF, which needs the top ROM address bit. The wide I/O address lets the bench put random noise on the upper byte and show that it is ignored. The 3-bit bank lets writes with upper data bits set show that those bits are dropped.

// File: rtl/cpu_dec_pkg.sv
package cpu_dec_pkg;

  typedef struct packed {
    logic rom_fix;
    logic rom_bank;
    logic wram;
    logic pal_lo;
    logic pal_hi;
    logic tile_lo;
    logic tile_hi;
    logic color;
    logic hole;
  } mem_sel_t;

  localparam int unsigned FIX_END   = 32'h8000;
  localparam int unsigned WIN_END   = 32'hC000;
  localparam int unsigned WRAM_END  = 32'hC800;
  localparam int unsigned PLO_END   = 32'hCC00;
  localparam int unsigned PHI_END   = 32'hD000;
  localparam int unsigned TLO_END   = 32'hD800;
  localparam int unsigned THI_END   = 32'hE000;
  localparam int unsigned COL_END   = 32'hE800;

  localparam int unsigned N_DSW     = 4;
  localparam int unsigned N_INP     = 3;

endpackage

// File: rtl/mem_decoder.sv
module mem_decoder
  import cpu_dec_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned ROM_AW   = 18,
  parameter int unsigned BANK_W   = 3,
  parameter int unsigned WIN_AW   = 14,
  parameter int unsigned ROM_BASE = 32'h10000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  output mem_sel_t          sel_o,
  output logic [ROM_AW-1:0] rom_addr_o
);

  localparam int unsigned FIX_AW = ADDR_W - 1;

  logic        acc;
  int unsigned a;

  assign acc = rd_i | wr_i;
  assign a   = 32'(addr_i);

  always_comb begin
    sel_o         = '0;
    sel_o.rom_fix = rd_i && (a < FIX_END);
    sel_o.rom_bank= rd_i && (a >= FIX_END)  && (a < WIN_END);
    sel_o.wram    = acc  && (a >= WIN_END)  && (a < WRAM_END);
    sel_o.pal_lo  = acc  && (a >= WRAM_END) && (a < PLO_END);
    sel_o.pal_hi  = acc  && (a >= PLO_END)  && (a < PHI_END);
    sel_o.tile_lo = acc  && (a >= PHI_END)  && (a < TLO_END);
    sel_o.tile_hi = acc  && (a >= TLO_END)  && (a < THI_END);
    sel_o.color   = acc  && (a >= THI_END)  && (a < COL_END);
    sel_o.hole    = rd_i && (a >= COL_END);
  end

  logic [ROM_AW-1:0] win_addr, fix_addr;
  assign win_addr = ROM_AW'(ROM_BASE) + (ROM_AW'(bank_i) << WIN_AW)
                  + ROM_AW'(addr_i[WIN_AW-1:0]);
  assign fix_addr = ROM_AW'(addr_i[FIX_AW-1:0]);
  assign rom_addr_o = sel_o.rom_bank ? win_addr : fix_addr;

  // R12: decoded regions never overlap
  always_comb begin
    a_sel_onehot_r12: assert ($onehot0(sel_o))
      else $error("memory selects overlap");
    // R2: window accesses land at or above the banked base
    if (sel_o.rom_bank)
      a_win_base_r2: assert (32'(rom_addr_o) >= ROM_BASE)
        else $error("window address below base");
  end

endmodule

// File: rtl/io_decoder.sv
module io_decoder
  import cpu_dec_pkg::*;
#(
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned DEC_W    = 8,
  parameter logic [7:0]  BANK_PORT= 8'hA0,
  parameter logic [7:0]  SND_PORT = 8'h40,
  parameter logic [7:0]  DSW_STEP = 8'h20
) (
  input  logic [IO_AW-1:0] addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic [N_DSW-1:0] dsw_rd_o,
  output logic [N_INP-1:0] in_rd_o,
  output logic             snd_wr_o,
  output logic             snd_a0_o,
  output logic             bank_we_o
);

  localparam logic [7:0] INP_PORT [N_INP] = '{8'h80, 8'hA0, 8'hE0};

  logic [DEC_W-1:0] lo;
  logic             unused_io_hi;

  assign lo           = addr_i[DEC_W-1:0];
  assign unused_io_hi = ^addr_i[IO_AW-1:DEC_W];

  for (genvar k = 0; k < N_DSW; k++) begin : g_dsw
    assign dsw_rd_o[k] = rd_i && (lo == DEC_W'(DSW_STEP * k));
  end

  for (genvar k = 0; k < N_INP; k++) begin : g_inp
    assign in_rd_o[k] = rd_i && (lo == DEC_W'(INP_PORT[k]));
  end

  assign snd_wr_o  = wr_i && (lo[DEC_W-1:1] == SND_PORT[DEC_W-1:1]);
  assign snd_a0_o  = lo[0];
  assign bank_we_o = wr_i && (lo == DEC_W'(BANK_PORT));

  // R9: one read strobe at a time
  always_comb begin
    a_rd_onehot_r9: assert ($onehot0({dsw_rd_o, in_rd_o}))
      else $error("io read strobes overlap");
    a_wr_excl_r10: assert (!(snd_wr_o && bank_we_o))
      else $error("sound and bank writes overlap");
  end

endmodule

// File: rtl/bank_reg.sv
module bank_reg #(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BANK_W-1:0] bank_o
);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:BANK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_o <= '0;
    else if (we_i) bank_o <= wdata_i[BANK_W-1:0];
  end

  p_bank_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bank_o));
  p_bank_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> bank_o == $past(wdata_i[BANK_W-1:0]));

endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vblank_i,
  input  logic ack_i,
  output logic irq_o
);

  logic vb_q, rise;
  assign rise = vblank_i & ~vb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb_q  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      vb_q <= vblank_i;
      if (rise)       irq_o <= 1'b1;
      else if (ack_i) irq_o <= 1'b0;
    end
  end

  p_irq_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> irq_o);
  p_irq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o);
  p_irq_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !rise |=> !irq_o);

endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
  import cpu_dec_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BANK_W   = 3,
  parameter int unsigned WIN_AW   = 14,
  parameter int unsigned ROM_BASE = 32'h10000,
  parameter int unsigned ROM_AW   = $clog2(ROM_BASE + (1 << (WIN_AW + BANK_W)))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  input  logic              vblank_i,
  input  logic              irq_ack_i,
  output logic              rom_fix_cs_o,
  output logic              rom_bank_cs_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              wram_cs_o,
  output logic              pal_lo_cs_o,
  output logic              pal_hi_cs_o,
  output logic              tile_lo_cs_o,
  output logic              tile_hi_cs_o,
  output logic              color_cs_o,
  output logic              hole_rd_o,
  output logic [N_DSW-1:0]  dsw_rd_o,
  output logic [N_INP-1:0]  in_rd_o,
  output logic              snd_wr_o,
  output logic              snd_a0_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              irq_o
);

  mem_sel_t sel;
  logic     bank_we;

  mem_decoder #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .BANK_W(BANK_W),
    .WIN_AW(WIN_AW), .ROM_BASE(ROM_BASE)
  ) u_mem (
    .addr_i(mem_addr_i), .rd_i(mem_rd_i), .wr_i(mem_wr_i),
    .bank_i(bank_o), .sel_o(sel), .rom_addr_o(rom_addr_o)
  );

  io_decoder #(.IO_AW(IO_AW)) u_io (
    .addr_i(io_addr_i), .rd_i(io_rd_i), .wr_i(io_wr_i),
    .dsw_rd_o(dsw_rd_o), .in_rd_o(in_rd_o),
    .snd_wr_o(snd_wr_o), .snd_a0_o(snd_a0_o), .bank_we_o(bank_we)
  );

  bank_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bank_we),
    .wdata_i(io_wdata_i), .bank_o(bank_o)
  );

  irq_latch u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .vblank_i(vblank_i),
    .ack_i(irq_ack_i), .irq_o(irq_o)
  );

  assign rom_fix_cs_o  = sel.rom_fix;
  assign rom_bank_cs_o = sel.rom_bank;
  assign wram_cs_o     = sel.wram;
  assign pal_lo_cs_o   = sel.pal_lo;
  assign pal_hi_cs_o   = sel.pal_hi;
  assign tile_lo_cs_o  = sel.tile_lo;
  assign tile_hi_cs_o  = sel.tile_hi;
  assign color_cs_o    = sel.color;
  assign hole_rd_o     = sel.hole;

  // R12: idle bus drives nothing
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_i || mem_wr_i || io_rd_i || io_wr_i) |->
      !(rom_fix_cs_o || rom_bank_cs_o || wram_cs_o || pal_lo_cs_o ||
        pal_hi_cs_o || tile_lo_cs_o || tile_hi_cs_o || color_cs_o ||
        hole_rd_o || snd_wr_o) && dsw_rd_o == '0 && in_rd_o == '0);
  // R4: reading the shared port leaves the bank alone
  p_shared_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rd_o[1] && !io_wr_i |=> $stable(bank_o));

endmodule

// File: tb/tb_cpu_bus_decoder.sv
module tb_cpu_bus_decoder;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic [15:0] mem_addr = '0;
  logic        mem_rd = 0, mem_wr = 0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 0, io_wr = 0;
  logic [7:0]  io_wdata = '0;
  logic        vblank = 0, irq_ack = 0;

  logic        rom_fix_cs, rom_bank_cs, wram_cs, pal_lo_cs, pal_hi_cs;
  logic        tile_lo_cs, tile_hi_cs, color_cs, hole_rd;
  logic [17:0] rom_addr;
  logic [3:0]  dsw_rd;
  logic [2:0]  in_rd;
  logic        snd_wr, snd_a0, irq;
  logic [2:0]  bank;

  int total = 0, bad = 0;
  logic [2:0] mdl_bank = 0;

  always #5 clk = ~clk;

  cpu_bus_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_i(mem_addr), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr), .io_wdata_i(io_wdata),
    .vblank_i(vblank), .irq_ack_i(irq_ack),
    .rom_fix_cs_o(rom_fix_cs), .rom_bank_cs_o(rom_bank_cs), .rom_addr_o(rom_addr),
    .wram_cs_o(wram_cs), .pal_lo_cs_o(pal_lo_cs), .pal_hi_cs_o(pal_hi_cs),
    .tile_lo_cs_o(tile_lo_cs), .tile_hi_cs_o(tile_hi_cs), .color_cs_o(color_cs),
    .hole_rd_o(hole_rd), .dsw_rd_o(dsw_rd), .in_rd_o(in_rd),
    .snd_wr_o(snd_wr), .snd_a0_o(snd_a0), .bank_o(bank), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // order: fix bank wram plo phi tlo thi col hole
  function automatic logic [8:0] exp_mem(input logic [15:0] a, input logic rd, input logic wr);
    logic acc = rd | wr;
    int   x   = int'(a);
    exp_mem = {rd  && x < 'h8000,
               rd  && x >= 'h8000 && x < 'hC000,
               acc && x >= 'hC000 && x < 'hC800,
               acc && x >= 'hC800 && x < 'hCC00,
               acc && x >= 'hCC00 && x < 'hD000,
               acc && x >= 'hD000 && x < 'hD800,
               acc && x >= 'hD800 && x < 'hE000,
               acc && x >= 'hE000 && x < 'hE800,
               rd  && x >= 'hE800};
  endfunction

  function automatic logic [17:0] exp_rom(input logic [15:0] a, input logic [2:0] b);
    if (a < 16'h8000) exp_rom = {3'b0, a[14:0]};
    else              exp_rom = 18'h10000 + {b, 14'h0} + {4'h0, a[13:0]};
  endfunction

  function automatic logic [6:0] exp_io(input logic [7:0] lo, input logic rd);
    logic [3:0] d; logic [2:0] n;
    for (int k = 0; k < 4; k++) d[k] = rd && lo == 8'(k * 'h20);
    n[0] = rd && lo == 8'h80;
    n[1] = rd && lo == 8'hA0;
    n[2] = rd && lo == 8'hE0;
    exp_io = {d, n};
  endfunction

  task automatic mem_cycle(input logic [15:0] a, input logic rd, input logic wr, input string req);
    logic [8:0] e;
    @(negedge clk);
    mem_addr = a; mem_rd = rd; mem_wr = wr;
    #1;
    e = exp_mem(a, rd, wr);
    chk(req, {rom_fix_cs, rom_bank_cs, wram_cs, pal_lo_cs, pal_hi_cs,
              tile_lo_cs, tile_hi_cs, color_cs, hole_rd}, e);
    if (e[8] || e[7]) chk(req, rom_addr, exp_rom(a, mdl_bank));
    mem_rd = 0; mem_wr = 0;
  endtask

  task automatic io_cycle(input logic [15:0] a, input logic rd, input logic wr,
                          input logic [7:0] d, input string req);
    logic es;
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
    #1;
    chk(req, {dsw_rd, in_rd}, exp_io(a[7:0], rd));
    es = wr && a[7:1] == 7'h20;
    chk(req, snd_wr, es);
    if (es) chk(req, snd_a0, a[0]);
    @(posedge clk); #1;
    if (wr && a[7:0] == 8'hA0) mdl_bank = d[2:0];
    io_rd = 0; io_wr = 0;
    chk(req, bank, mdl_bank);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0DE5EED));
    #23 rst_ni = 1;
    #1;
    // reset state (R3, R11, R12)
    chk("R3 reset bank", bank, 0);
    chk("R11 reset irq", irq, 0);
    chk("R12 idle", {rom_fix_cs, wram_cs, hole_rd, dsw_rd, in_rd, snd_wr}, 0);

    // directed boundaries
    mem_cycle(16'h0000, 1, 0, "R1 fix lo");
    mem_cycle(16'h7FFF, 1, 0, "R1 fix hi");
    mem_cycle(16'h8000, 1, 0, "R2 win bank0");
    mem_cycle(16'hBFFF, 1, 0, "R2 win end");
    mem_cycle(16'hC000, 0, 1, "R5 wram");
    mem_cycle(16'hC7FF, 1, 0, "R5 wram end");
    mem_cycle(16'hC800, 0, 1, "R5 pal lo");
    mem_cycle(16'hCC00, 1, 0, "R5 pal hi");
    mem_cycle(16'hCFFF, 0, 1, "R5 pal hi end");
    mem_cycle(16'hD000, 1, 0, "R6 tile lo");
    mem_cycle(16'hD800, 0, 1, "R6 tile hi");
    mem_cycle(16'hE7FF, 1, 0, "R6 color end");
    mem_cycle(16'hE800, 1, 0, "R7 hole start");
    mem_cycle(16'hFFFF, 1, 0, "R7 hole end");
    mem_cycle(16'hF000, 0, 1, "R7 hole write");
    mem_cycle(16'h4000, 0, 1, "R12 rom write ignored");
    mem_cycle(16'hC100, 0, 0, "R12 no strobe");

    // bank register, upper data bits ignored
    io_cycle(16'h00A0, 0, 1, 8'hFF, "R3 bank write 7");
    mem_cycle(16'hBFFF, 1, 0, "R2 win bank7 top");
    io_cycle(16'h00A0, 1, 0, 8'h02, "R4 shared read");
    chk("R4 bank kept", bank, 3'd7);
    io_cycle(16'h00A1, 0, 1, 8'h02, "R3 near port no write");
    io_cycle(16'h5AA0, 0, 1, 8'hFA, "R8 high byte ignored");
    mem_cycle(16'h8123, 1, 0, "R2 win bank2");

    // io strobes
    for (int k = 0; k < 4; k++)
      io_cycle(16'h3300 | 16'(k * 'h20), 1, 0, 8'h00, "R9 dsw");
    io_cycle(16'h0080, 1, 0, 0, "R9 in0");
    io_cycle(16'hFFE0, 1, 0, 0, "R9 in2 R8");
    io_cycle(16'h0040, 0, 1, 0, "R10 snd addr");
    io_cycle(16'h8041, 0, 1, 0, "R10 snd data");
    io_cycle(16'h0040, 1, 0, 0, "R10 read not snd");
    io_cycle(16'h0042, 0, 1, 0, "R10 off port");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a = 16'($urandom);
      int op = $urandom_range(0, 3);
      if (op == 0) mem_cycle(a, 1, 0, "R1 R2 R5 R6 R7 rand rd");
      else if (op == 1) mem_cycle(a, 0, 1, "R5 R6 R12 rand wr");
      else begin
        logic [15:0] ia = {8'($urandom), 3'($urandom), 5'($urandom_range(0, 1) ? 0 : $urandom)};
        io_cycle(ia, op == 2, op == 3, 8'($urandom), "R3 R8 R9 R10 rand io");
      end
      if (i % 37 == 0) io_cycle({8'($urandom), 8'hA0}, 0, 1, 8'($urandom), "R3 rand bank");
    end

    // interrupt latch
    @(negedge clk); vblank = 1;
    @(negedge clk); chk("R11 set", irq, 1);
    repeat (3) @(negedge clk);
    chk("R11 held", irq, 1);
    irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R11 cleared", irq, 0);
    @(negedge clk); chk("R11 no retrigger on level", irq, 0);
    vblank = 0;
    @(negedge clk); vblank = 1; irq_ack = 1;
    @(negedge clk); vblank = 0; irq_ack = 0;
    chk("R11 edge beats ack", irq, 1);
    @(negedge clk); chk("R11 still held", irq, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule